// File: doc/BRIEF.md
# I2C Slave Port with Address Matching

This block is a slave-only serial port for the two-wire I2C bus. It runs on a fast system clock and oversamples the clock and data lines. Each line goes through a synchronizer and a glitch filter. From the filtered lines the block detects clock edges and the START and STOP bus conditions. It answers to a programmable address in either 7-bit or 10-bit form. It does not respond to the general-call address.

Received bytes are shifted in most significant bit first. A completed byte is moved into a receive buffer, where the host reads it through a simple register-style interface. The port drives the data line low to acknowledge. In transmit mode it holds the clock line low after each acknowledged byte until the host supplies the next byte. A single interrupt line is raised on START, on STOP and on an address match. The port does nothing until its enable input is high.

Top module: `i2cs_port`

## Requirements
- R1: A line change reaches the filtered value only after the synchronized input has held the new level for 3 consecutive system-clock samples. A 2-cycle pulse on SDA while SCL is high causes no START or STOP.
- R2: While `enable` is 0, the port drives neither line. All of its flags read 0, and bus traffic is not acknowledged.
- R3: A START (SDA falls while SCL is high) sets `start_flag`, clears `stop_flag` and `addr_match`, and sets `irq`. A STOP (SDA rises while SCL is high) sets `stop_flag`, clears `start_flag` and sets `irq`.
- R4: In 7-bit mode (`ten_bit_mode`=0), an address byte whose bits [7:1] equal `own_addr[6:0]` is acknowledged by pulling SDA low during the 9th clock. It also sets `addr_match` and `irq`, and copies bit 0 into `rw_flag` (1 = read). An address that does not match is not acknowledged, and the port ignores the bus until the next START.
- R5: The address byte 0x00 (general call) is never acknowledged, even when `own_addr` is 0.
- R6: After a write address has matched, each data byte is received MSb first. It is placed on `rd_data`, sets `buf_full`, and is acknowledged. A pulse on `rd_strobe` clears `buf_full`.
- R7: A data byte that completes while `buf_full` is 1 and no `rd_strobe` is present sets `overflow`. That byte is not acknowledged, and `rd_data` keeps its old value. `clr_flags` clears `overflow` and `irq`.
- R8: In 10-bit mode, the first address byte 11110,`own_addr[9:8]`,0 is acknowledged. A following byte equal to `own_addr[7:0]` is also acknowledged and sets `addr_match`. A second byte that differs is not acknowledged.
- R9: In 10-bit mode, after a full 10-bit match and a repeated START, the byte 11110,`own_addr[9:8]`,1 is acknowledged and enters transmit mode. After a STOP, that same byte is not acknowledged.
- R10: In transmit mode, the port holds SCL low after the address acknowledge, and after each byte the master acknowledges. It does so until `wr_valid` loads `wr_data`, which is then sent MSb first. When the master does not acknowledge, the port releases both lines and does not hold SCL.
- R11: A START or STOP in the middle of a byte abandons that byte, which is not stored. A repeated START mid-byte starts a fresh address phase.
- R12: When an interrupt event and `clr_flags` fall in the same cycle, `irq` is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Port enable |
| ten_bit_mode | input | 1 | 1 selects 10-bit addressing |
| own_addr | input | 10 | Slave address (bits [6:0] in 7-bit mode) |
| scl_in | input | 1 | SCL pin level |
| sda_in | input | 1 | SDA pin level |
| scl_drive_low | output | 1 | Pull SCL low (clock hold) |
| sda_drive_low | output | 1 | Pull SDA low (acknowledge or a 0 bit) |
| wr_valid | input | 1 | Load transmit byte (acts while SCL is held) |
| wr_data | input | 8 | Transmit byte |
| rd_strobe | input | 1 | Host has read the receive buffer |
| clr_flags | input | 1 | Clear `irq` and `overflow` |
| rd_data | output | 8 | Receive buffer |
| buf_full | output | 1 | Receive buffer holds an unread byte |
| overflow | output | 1 | A byte arrived while the buffer was full |
| start_flag | output | 1 | Last condition seen was START |
| stop_flag | output | 1 | Last condition seen was STOP |
| addr_match | output | 1 | Address matched in this transfer |
| rw_flag | output | 1 | Direction bit of the matched address |
| irq | output | 1 | Interrupt request |

## Verification
Two things can fall in the same cycle: a bus event that raises the interrupt, and the host clearing it. The bench provokes this by holding `clr_flags` high across a START and a STOP, so every event lands on a clear. A monitor must see `irq` high for at least one cycle, and `irq` must read 0 afterwards. The pairing of a buffer read with a byte arrival is also defined in the logic: the read happens first, so the new byte is stored without overflow.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;
    localparam int BYTE_W = 8;
    localparam int ADDR_W = 10;
    localparam logic [4:0] TEN_PREFIX = 5'b11110;

    typedef enum logic [2:0] {
        PH_IDLE, PH_ADDR, PH_ADDR_LO, PH_RX, PH_TX
    } phase_e;

    typedef struct packed {
        phase_e            phase;
        logic [3:0]        cnt;
        logic [BYTE_W-1:0] sh;
        logic [BYTE_W-1:0] tx;
        logic [BYTE_W-1:0] rbuf;
        logic              buf_full;
        logic              ovf;
        logic              s_flag;
        logic              p_flag;
        logic              match;
        logic              rw;
        logic              ten_ok;
        logic              nack;
        logic              sda_oe;
        logic              scl_oe;
        logic              irq;
    } eng_t;
endpackage

// File: rtl/i2cs_filter.sv
module i2cs_filter #(
    parameter int SYNC_STAGES = 2,
    parameter int FILT_LEN    = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    output logic level
);
    localparam int CW = $clog2(FILT_LEN + 1);

    logic [SYNC_STAGES-1:0] sync_q, sync_d;
    logic [CW-1:0]          cnt_q, cnt_d;
    logic                   filt_q, filt_d;
    logic                   raw;

    assign raw = sync_q[SYNC_STAGES-1];

    always_comb begin
        sync_d = {sync_q[SYNC_STAGES-2:0], pin};
        cnt_d  = cnt_q;
        filt_d = filt_q;
        if (raw == filt_q) begin
            cnt_d = '0;
        end else if (cnt_q == CW'(FILT_LEN - 1)) begin
            filt_d = raw;
            cnt_d  = '0;
        end else begin
            cnt_d = cnt_q + CW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '1;
            cnt_q  <= '0;
            filt_q <= 1'b1;
        end else begin
            sync_q <= sync_d;
            cnt_q  <= cnt_d;
            filt_q <= filt_d;
        end
    end

    assign level = filt_q;

    // R1: a new filtered level was present on the synchronized input beforehand
    a_r1_filter_steady: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(filt_q) |-> ($past(raw) == filt_q && $past(raw, 2) == filt_q));
endmodule

// File: rtl/i2cs_bus_events.sv
module i2cs_bus_events (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_f,
    input  logic sda_f,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic scl_p_q, scl_p_d, sda_p_q, sda_p_d;

    always_comb begin
        scl_p_d   = scl_f;
        sda_p_d   = sda_f;
        scl_rise  = scl_f & ~scl_p_q;
        scl_fall  = ~scl_f & scl_p_q;
        start_det = scl_f & scl_p_q & sda_p_q & ~sda_f;
        stop_det  = scl_f & scl_p_q & ~sda_p_q & sda_f;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_p_q <= 1'b1;
            sda_p_q <= 1'b1;
        end else begin
            scl_p_q <= scl_p_d;
            sda_p_q <= sda_p_d;
        end
    end
endmodule

// File: rtl/i2cs_engine.sv
module i2cs_engine
    import i2cs_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              ten_bit_mode,
    input  logic [ADDR_W-1:0] own_addr,
    input  logic              scl_f,
    input  logic              sda_f,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_det,
    input  logic              stop_det,
    input  logic              wr_valid,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic              rd_strobe,
    input  logic              clr_flags,
    output eng_t              st
);
    eng_t q, n;

    always_comb begin
        n = q;
        if (!enable) begin
            n = '0;
        end else begin
            if (rd_strobe) n.buf_full = 1'b0;
            if (clr_flags) begin
                n.irq = 1'b0;
                n.ovf = 1'b0;
            end
            if (start_det) begin
                n.phase  = PH_ADDR;
                n.cnt    = '0;
                n.sda_oe = 1'b0;
                n.scl_oe = 1'b0;
                n.s_flag = 1'b1;
                n.p_flag = 1'b0;
                n.match  = 1'b0;
                n.irq    = 1'b1;
            end else if (stop_det) begin
                n.phase  = PH_IDLE;
                n.cnt    = '0;
                n.sda_oe = 1'b0;
                n.scl_oe = 1'b0;
                n.s_flag = 1'b0;
                n.p_flag = 1'b1;
                n.match  = 1'b0;
                n.ten_ok = 1'b0;
                n.irq    = 1'b1;
            end else if (q.phase != PH_IDLE) begin
                if (scl_rise) begin
                    if (q.cnt < 4'd8) begin
                        n.sh  = {q.sh[BYTE_W-2:0], sda_f};
                        n.cnt = q.cnt + 4'd1;
                    end else if (q.cnt == 4'd8) begin
                        n.cnt  = 4'd9;
                        n.nack = sda_f;
                    end
                end
                if (scl_fall) begin
                    if (q.cnt == 4'd8) begin
                        n.sda_oe = 1'b0;
                        n.nack   = 1'b0;
                        unique case (q.phase)
                            PH_ADDR: begin
                                n.phase = PH_IDLE;
                                if (!ten_bit_mode) begin
                                    if (q.sh[7:1] == own_addr[6:0] && q.sh != 8'h00) begin
                                        n.phase  = q.sh[0] ? PH_TX : PH_RX;
                                        n.sda_oe = 1'b1;
                                        n.match  = 1'b1;
                                        n.rw     = q.sh[0];
                                        n.irq    = 1'b1;
                                    end
                                end else if (q.sh[7:1] == {TEN_PREFIX, own_addr[9:8]}) begin
                                    if (!q.sh[0]) begin
                                        n.phase  = PH_ADDR_LO;
                                        n.sda_oe = 1'b1;
                                    end else if (q.ten_ok) begin
                                        n.phase  = PH_TX;
                                        n.sda_oe = 1'b1;
                                        n.match  = 1'b1;
                                        n.rw     = 1'b1;
                                        n.irq    = 1'b1;
                                    end
                                end
                            end
                            PH_ADDR_LO: begin
                                n.phase = PH_IDLE;
                                if (q.sh == own_addr[7:0]) begin
                                    n.phase  = PH_RX;
                                    n.sda_oe = 1'b1;
                                    n.match  = 1'b1;
                                    n.rw     = 1'b0;
                                    n.ten_ok = 1'b1;
                                    n.irq    = 1'b1;
                                end
                            end
                            PH_RX: begin
                                if (q.buf_full && !rd_strobe) begin
                                    n.ovf = 1'b1;
                                end else begin
                                    n.rbuf     = q.sh;
                                    n.buf_full = 1'b1;
                                    n.sda_oe   = 1'b1;
                                end
                            end
                            default: ;
                        endcase
                    end else if (q.cnt == 4'd9) begin
                        n.sda_oe = 1'b0;
                        n.cnt    = '0;
                        if (q.phase == PH_TX) begin
                            if (q.nack) n.phase = PH_IDLE;
                            else        n.scl_oe = 1'b1;
                        end
                    end else if (q.phase == PH_TX && q.cnt != 4'd0) begin
                        n.tx     = {q.tx[BYTE_W-2:0], 1'b0};
                        n.sda_oe = ~q.tx[BYTE_W-2];
                    end
                end
                if (q.scl_oe && wr_valid) begin
                    n.tx     = wr_data;
                    n.sda_oe = ~wr_data[BYTE_W-1];
                    n.scl_oe = 1'b0;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= n;
    end

    assign st = q;

    a_r3_start_sets_flags: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && start_det) |=> (q.s_flag && !q.p_flag && q.irq && !q.match));
    a_r3_stop_sets_flags: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && stop_det) |=> (q.p_flag && !q.s_flag && q.irq));
    a_r2_quiet_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (!q.sda_oe && !q.scl_oe && !q.s_flag && !q.irq));
    a_r10_write_releases_scl: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && q.scl_oe && wr_valid && !start_det && !stop_det) |=> !q.scl_oe);
    a_r4_sda_moves_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.sda_oe) |-> !scl_f);
    a_r7_overflow_needs_full: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.ovf) |-> $past(q.buf_full));
    a_r12_event_beats_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && (start_det || stop_det)) |=> q.irq);
endmodule

// File: rtl/i2cs_port.sv
module i2cs_port
    import i2cs_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int FILT_LEN    = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              ten_bit_mode,
    input  logic [ADDR_W-1:0] own_addr,
    input  logic              scl_in,
    input  logic              sda_in,
    output logic              scl_drive_low,
    output logic              sda_drive_low,
    input  logic              wr_valid,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic              rd_strobe,
    input  logic              clr_flags,
    output logic [BYTE_W-1:0] rd_data,
    output logic              buf_full,
    output logic              overflow,
    output logic              start_flag,
    output logic              stop_flag,
    output logic              addr_match,
    output logic              rw_flag,
    output logic              irq
);
    localparam int LINES = 2;

    logic [LINES-1:0] pins, lvl;
    logic scl_rise, scl_fall, start_det, stop_det;
    eng_t st;

    assign pins = {sda_in, scl_in};

    for (genvar i = 0; i < LINES; i++) begin : g_line
        i2cs_filter #(.SYNC_STAGES(SYNC_STAGES), .FILT_LEN(FILT_LEN)) u_filt (
            .clk(clk), .rst_n(rst_n), .pin(pins[i]), .level(lvl[i])
        );
    end

    i2cs_bus_events u_ev (
        .clk(clk), .rst_n(rst_n), .scl_f(lvl[0]), .sda_f(lvl[1]),
        .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det)
    );

    i2cs_engine u_eng (
        .clk(clk), .rst_n(rst_n), .enable(enable), .ten_bit_mode(ten_bit_mode),
        .own_addr(own_addr), .scl_f(lvl[0]), .sda_f(lvl[1]),
        .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det),
        .wr_valid(wr_valid), .wr_data(wr_data),
        .rd_strobe(rd_strobe), .clr_flags(clr_flags), .st(st)
    );

    assign scl_drive_low = st.scl_oe;
    assign sda_drive_low = st.sda_oe;
    assign rd_data       = st.rbuf;
    assign buf_full      = st.buf_full;
    assign overflow      = st.ovf;
    assign start_flag    = st.s_flag;
    assign stop_flag     = st.p_flag;
    assign addr_match    = st.match;
    assign rw_flag       = st.rw;
    assign irq           = st.irq;
endmodule

// File: tb/tb_i2cs_port.sv
module tb_i2cs_port;
    localparam int H = 30;
    localparam int Q = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic enable = 1'b0, ten_bit_mode = 1'b0;
    logic [9:0] own_addr = 10'h052;
    logic m_scl = 1'b1, m_sda = 1'b1, g_low = 1'b0;
    logic wr_valid = 1'b0, rd_strobe = 1'b0, clr_flags = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic scl_dl, sda_dl, buf_full, overflow, start_flag, stop_flag, addr_match, rw_flag, irq;
    logic [7:0] rd_data;
    int checks = 0, errors = 0;
    logic irq_seen = 1'b0;

    wire scl_bus = m_scl & ~scl_dl;
    wire sda_bus = m_sda & ~sda_dl & ~g_low;

    always #2.5 clk = ~clk;

    i2cs_port dut (
        .clk(clk), .rst_n(rst_n), .enable(enable), .ten_bit_mode(ten_bit_mode),
        .own_addr(own_addr), .scl_in(scl_bus), .sda_in(sda_bus),
        .scl_drive_low(scl_dl), .sda_drive_low(sda_dl),
        .wr_valid(wr_valid), .wr_data(wr_data), .rd_strobe(rd_strobe),
        .clr_flags(clr_flags), .rd_data(rd_data), .buf_full(buf_full),
        .overflow(overflow), .start_flag(start_flag), .stop_flag(stop_flag),
        .addr_match(addr_match), .rw_flag(rw_flag), .irq(irq)
    );

    always @(negedge clk) if (irq) irq_seen = 1'b1;

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wait_high();
        while (!scl_bus) tick(1);
    endtask

    task automatic pulse_rd();
        rd_strobe = 1'b1; tick(1); rd_strobe = 1'b0;
    endtask

    task automatic pulse_clr();
        clr_flags = 1'b1; tick(1); clr_flags = 1'b0;
    endtask

    task automatic host_write(input logic [7:0] b);
        wr_data = b; wr_valid = 1'b1; tick(1); wr_valid = 1'b0;
    endtask

    task automatic m_start();
        m_sda = 1'b1; m_scl = 1'b1; tick(H);
        m_sda = 1'b0; tick(H);
        m_scl = 1'b0; tick(Q);
    endtask

    task automatic m_rstart();
        m_sda = 1'b1; tick(H);
        m_scl = 1'b1; tick(H);
        m_sda = 1'b0; tick(H);
        m_scl = 1'b0; tick(Q);
    endtask

    task automatic m_stop();
        m_sda = 1'b0; tick(H);
        m_scl = 1'b1; tick(H);
        m_sda = 1'b1; tick(H);
    endtask

    task automatic send_bits(input logic [7:0] b, input int n);
        for (int i = 0; i < n; i++) begin
            m_sda = b[7-i]; tick(H);
            m_scl = 1'b1; wait_high(); tick(H);
            m_scl = 1'b0; tick(Q);
        end
    endtask

    task automatic send_byte(input logic [7:0] b, output logic acked);
        send_bits(b, 8);
        m_sda = 1'b1; tick(H);
        m_scl = 1'b1; wait_high(); tick(H/2);
        acked = ~sda_bus; tick(H/2);
        m_scl = 1'b0; tick(Q);
    endtask

    task automatic recv_byte(input logic ack_it, output logic [7:0] b);
        for (int i = 7; i >= 0; i--) begin
            m_sda = 1'b1; tick(H);
            m_scl = 1'b1; wait_high(); tick(H/2);
            b[i] = sda_bus; tick(H/2);
            m_scl = 1'b0; tick(Q);
        end
        m_sda = ~ack_it; tick(H);
        m_scl = 1'b1; wait_high(); tick(H);
        m_scl = 1'b0; tick(Q);
        m_sda = 1'b1;
    endtask

    task automatic t_reset();
        chk("R2 reset sda", {31'd0, sda_dl}, 0);
        chk("R2 reset scl", {31'd0, scl_dl}, 0);
        chk("R3 reset flags", {28'd0, start_flag, stop_flag, irq, buf_full}, 0);
    endtask

    task automatic t_start_stop();
        pulse_clr();
        m_start();
        chk("R3 start flag", {30'd0, start_flag, stop_flag}, 32'h2);
        chk("R3 start irq", {31'd0, irq}, 1);
        pulse_clr();
        m_stop();
        chk("R3 stop flag", {30'd0, start_flag, stop_flag}, 32'h1);
        chk("R3 stop irq", {31'd0, irq}, 1);
    endtask

    task automatic t_glitch();
        pulse_clr();
        g_low = 1'b1; tick(2); g_low = 1'b0; tick(H);
        chk("R1 short pulse ignored", {30'd0, start_flag, irq}, 0);
        g_low = 1'b1; tick(10); g_low = 1'b0;
        chk("R1 long pulse is start", {31'd0, start_flag}, 1);
        tick(H);
        chk("R1 release is stop", {31'd0, stop_flag}, 1);
    endtask

    task automatic t_write7();
        logic a;
        own_addr = 10'h052; ten_bit_mode = 1'b0;
        m_start();
        pulse_clr();
        send_byte(8'hA4, a);
        chk("R4 address ack", {31'd0, a}, 1);
        chk("R4 match flags", {29'd0, addr_match, rw_flag, irq}, 32'h5);
        send_byte(8'h9C, a);
        chk("R6 data ack", {31'd0, a}, 1);
        chk("R6 data value", {24'd0, rd_data}, 32'h9C);
        chk("R6 buffer full", {31'd0, buf_full}, 1);
        pulse_rd();
        chk("R6 read clears full", {31'd0, buf_full}, 0);
        send_byte(8'h01, a);
        chk("R6 second byte", {24'd0, rd_data}, 32'h01);
        send_byte(8'h77, a);
        chk("R7 overflow nack", {31'd0, a}, 0);
        chk("R7 overflow flag", {31'd0, overflow}, 1);
        chk("R7 buffer kept", {24'd0, rd_data}, 32'h01);
        m_stop();
        pulse_clr();
        chk("R7 clear flags", {30'd0, overflow, irq}, 0);
        pulse_rd();
    endtask

    task automatic t_mismatch();
        logic a;
        m_start();
        send_byte(8'hA6, a);
        chk("R4 mismatch nack", {31'd0, a}, 0);
        chk("R4 mismatch no match", {31'd0, addr_match}, 0);
        send_byte(8'h11, a);
        chk("R4 ignored after mismatch", {30'd0, a, buf_full}, 0);
        m_stop();
    endtask

    task automatic t_gcall();
        logic a;
        own_addr = 10'h000;
        m_start();
        send_byte(8'h00, a);
        chk("R5 general call nack", {31'd0, a}, 0);
        chk("R5 no match", {31'd0, addr_match}, 0);
        m_stop();
        own_addr = 10'h052;
    endtask

    task automatic t_read7();
        logic a;
        logic [7:0] b;
        m_start();
        send_byte(8'hA5, a);
        chk("R10 read address ack", {30'd0, a, rw_flag}, 32'h3);
        m_scl = 1'b1; tick(H);
        chk("R10 hold after address", {31'd0, scl_bus}, 0);
        host_write(8'hC3);
        recv_byte(1'b1, b);
        chk("R10 first byte", {24'd0, b}, 32'hC3);
        m_scl = 1'b1; tick(H);
        chk("R10 hold after master ack", {31'd0, scl_bus}, 0);
        host_write(8'h5A);
        recv_byte(1'b0, b);
        chk("R10 second byte", {24'd0, b}, 32'h5A);
        m_scl = 1'b1; tick(H);
        chk("R10 released on nack", {30'd0, scl_bus, sda_bus}, 32'h3);
        m_scl = 1'b0; tick(Q);
        m_stop();
    endtask

    task automatic t_ten();
        logic a;
        logic [7:0] b;
        ten_bit_mode = 1'b1; own_addr = 10'h2B5;
        m_start();
        send_byte(8'hF4, a);
        chk("R8 high byte ack", {31'd0, a}, 1);
        send_byte(8'hB5, a);
        chk("R8 low byte ack", {30'd0, a, addr_match}, 32'h3);
        send_byte(8'h66, a);
        chk("R8 data after 10-bit", {24'd0, rd_data}, 32'h66);
        pulse_rd();
        m_rstart();
        send_byte(8'hF5, a);
        chk("R9 read after repeated start", {30'd0, a, rw_flag}, 32'h3);
        m_scl = 1'b1; tick(H);
        host_write(8'h81);
        recv_byte(1'b0, b);
        chk("R9 transmit byte", {24'd0, b}, 32'h81);
        m_scl = 1'b0; tick(Q);
        m_stop();
        m_start();
        send_byte(8'hF5, a);
        chk("R9 read without prior match", {31'd0, a}, 0);
        m_stop();
        m_start();
        send_byte(8'hF4, a);
        send_byte(8'hB4, a);
        chk("R8 wrong low byte", {30'd0, a, addr_match}, 0);
        m_stop();
        ten_bit_mode = 1'b0; own_addr = 10'h052;
    endtask

    task automatic t_abort();
        logic a;
        m_start();
        send_bits(8'hF0, 4);
        m_rstart();
        send_byte(8'hA4, a);
        chk("R11 restart mid-byte then ack", {31'd0, a}, 1);
        send_byte(8'h3E, a);
        chk("R11 data after abort", {24'd0, rd_data}, 32'h3E);
        pulse_rd();
        send_bits(8'hFF, 5);
        m_stop();
        chk("R11 partial byte dropped", {30'd0, buf_full, stop_flag}, 32'h1);
        chk("R11 buffer unchanged", {24'd0, rd_data}, 32'h3E);
    endtask

    task automatic t_disabled();
        logic a;
        enable = 1'b0; tick(2);
        chk("R2 flags cleared", {27'd0, start_flag, stop_flag, irq, buf_full, addr_match}, 0);
        m_start();
        send_byte(8'hA4, a);
        chk("R2 no ack when off", {31'd0, a}, 0);
        chk("R2 no start when off", {31'd0, start_flag}, 0);
        m_stop();
        enable = 1'b1; tick(2);
    endtask

    task automatic t_collide();
        clr_flags = 1'b1; tick(1);
        irq_seen = 1'b0;
        m_start();
        chk("R12 irq set against clear", {31'd0, irq_seen}, 1);
        chk("R12 irq cleared afterwards", {31'd0, irq}, 0);
        irq_seen = 1'b0;
        m_stop();
        chk("R12 stop irq against clear", {31'd0, irq_seen}, 1);
        clr_flags = 1'b0; tick(1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        tick(5);
        rst_n = 1'b1;
        tick(5);
        t_reset();
        enable = 1'b1; tick(2);
        t_start_stop();
        t_glitch();
        t_write7();
        t_mismatch();
        t_gcall();
        t_read7();
        t_ten();
        t_abort();
        t_disabled();
        t_collide();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule